// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block divides a single clock into instruction cycles of four sub-phases and runs a two-stage pipeline. While one instruction executes, the next one is fetched. The block supplies the program-counter address to instruction memory. It captures the returned 16-bit word in a prefetch register and moves it into the instruction register at the start of the next instruction cycle. It also emits one-hot phase strobes plus operand-read and result-write strobes for data memory.

Execute logic outside the block decodes the instruction register. It raises a branch request with a target address when the instruction changes program flow. The sequencer then loads the target, throws away the word it has already prefetched, and executes an all-zero no-operation word in its place. It flags that no-operation word so the datapath can suppress every side effect. A taken branch therefore costs exactly one extra instruction cycle.

Top module: `qseq_core`

## Requirements
- R1: While synchronous reset is high, and in the first clock after it, `phase` is 4'b0001 (Q1), `imem_addr` is 0, `ir` is 0 (the no-operation encoding) and `ir_flushed` is 0.
- R2: `phase` is always one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. Each phase lasts one clock, and the phases repeat Q1, Q2, Q3, Q4. One pass through the four phases is one instruction cycle.
- R3: `imem_addr` changes only on entry to Q1. Without a taken branch it advances by 2, modulo 2^PC_W.
- R4: The word on `imem_data` in the Q3 clock of an instruction cycle appears on `ir` for the whole of the following instruction cycle, unless a branch is taken in between.
- R5: `ir` and `ir_flushed` change only on entry to Q1.
- R6: `dmem_rd` is high exactly in the Q2 clock and `dmem_wr` exactly in the Q4 clock of every instruction cycle whose `ir_flushed` is 0. Both are low at all other times.
- R7: `br_req` and `br_target` are sampled only in the Q4 clock. If a branch is taken there, `imem_addr` equals the sampled target during the next cycle. Values on these inputs in Q1 to Q3 have no effect.
- R8: In the instruction cycle after a taken branch, `ir` is 0 and `ir_flushed` is 1. In the cycle after that, `ir` holds the word fetched from the target address.
- R9: A branch request during a cycle whose `ir_flushed` is 1 is ignored.
- R10: `ir_flushed` is 0 in every cycle that does not directly follow a taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; each edge advances one sub-phase |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | PC_W | Byte address of the instruction being fetched |
| imem_data | input | IW | Instruction word returned by program memory |
| br_req | input | 1 | Branch request from execute logic |
| br_target | input | PC_W | Branch target byte address |
| phase | output | 4 | One-hot phase strobes Q1..Q4 |
| ir | output | IW | Instruction register (instruction under execution) |
| ir_flushed | output | 1 | High while `ir` holds a forced no-operation |
| dmem_rd | output | 1 | Data-memory operand-read strobe |
| dmem_wr | output | 1 | Data-memory result-write strobe |

## Verification
The assertions check the following on every clock:
- `phase` stays one-hot and wraps from Q4 to Q1.
- The PC and the instruction register hold still outside the Q1 boundary.
- The PC steps by 2 when no branch is taken, and a taken branch loads the target.
- A forced no-operation word is zero and blocks a second branch.
- The strobes appear only in their own phase.

Only the bench's scenarios can show that the word fetched in Q3 reaches execution one cycle later, that the fetch after a branch returns the target's word, and that the PC wraps at the top of the address space. Those scenarios also cover branch requests raised outside Q4 and requests held high across consecutive cycles.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam int NUM_PHASES = 4;
    localparam int ADDR_STEP  = 2;   // byte step between 16-bit instruction words
endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
    import qseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    output logic [NUM_PHASES-1:0] strobe_o
);
    typedef struct packed {
        phase_e ph;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = phase_e'(st_q.ph + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{ph: PH_Q1};
        else     st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_strobe
        localparam logic [1:0] IDX = i;
        assign strobe_o[i] = (st_q.ph == IDX);
    end

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(strobe_o)) else $error("phase not one-hot"); // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        strobe_o[NUM_PHASES-1] |=> strobe_o[0]) else $error("Q4 not followed by Q1"); // R2
endmodule

// File: rtl/qseq_pc_unit.sv
module qseq_pc_unit
    import qseq_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_i,     // last clock of the instruction cycle
    input  logic            take_i,    // taken branch, valid with adv_i
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] pc_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(ADDR_STEP);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            if (take_i) st_d.pc = target_i;
            else        st_d.pc = st_q.pc + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pc: '0};
        else     st_q <= st_d;
    end

    assign pc_o = st_q.pc;

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(pc_o)) else $error("PC moved outside Q1 entry"); // R3
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !take_i) |=> (pc_o == $past(pc_o) + STEP)) else $error("PC step wrong"); // R3
endmodule

// File: rtl/qseq_ir_stage.sv
module qseq_ir_stage #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_i,     // last clock of Q3: capture fetched word
    input  logic          adv_i,     // last clock of Q4: move word to execute
    input  logic          take_i,    // taken branch: replace word with forced NOP
    input  logic [IW-1:0] word_i,
    output logic [IW-1:0] ir_o,
    output logic          flushed_o
);
    localparam logic [IW-1:0] NOP = '0;

    typedef struct packed {
        logic [IW-1:0] pf;
        logic [IW-1:0] ir;
        logic          fl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i) st_d.pf = word_i;
        if (adv_i) begin
            if (take_i) begin
                st_d.ir = NOP;
                st_d.fl = 1'b1;
            end else begin
                st_d.ir = st_q.pf;
                st_d.fl = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pf: NOP, ir: NOP, fl: 1'b0};
        else     st_q <= st_d;
    end

    assign ir_o      = st_q.ir;
    assign flushed_o = st_q.fl;

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> ($stable(ir_o) && $stable(flushed_o))) else $error("IR moved mid-cycle"); // R5
    AST_FLUSH_IS_NOP: assert property (@(posedge clk) disable iff (rst)
        flushed_o |-> (ir_o == NOP)) else $error("flushed word not NOP"); // R8
endmodule

// File: rtl/qseq_core.sv
module qseq_core
    import qseq_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int IW   = 16
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PC_W-1:0] imem_addr,
    input  logic [IW-1:0]   imem_data,
    input  logic            br_req,
    input  logic [PC_W-1:0] br_target,
    output logic [3:0]      phase,
    output logic [IW-1:0]   ir,
    output logic            ir_flushed,
    output logic            dmem_rd,
    output logic            dmem_wr
);
    logic [NUM_PHASES-1:0] strobe;
    logic                  take;

    qseq_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .strobe_o (strobe)
    );

    // A branch is honoured only at the end of a real (non-flushed) execute cycle.
    assign take = br_req & ~ir_flushed & strobe[PH_Q4];

    qseq_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .adv_i    (strobe[PH_Q4]),
        .take_i   (take),
        .target_i (br_target),
        .pc_o     (imem_addr)
    );

    qseq_ir_stage #(.IW(IW)) u_ir (
        .clk       (clk),
        .rst       (rst),
        .cap_i     (strobe[PH_Q3]),
        .adv_i     (strobe[PH_Q4]),
        .take_i    (take),
        .word_i    (imem_data),
        .ir_o      (ir),
        .flushed_o (ir_flushed)
    );

    assign phase   = strobe;
    assign dmem_rd = strobe[PH_Q2] & ~ir_flushed;
    assign dmem_wr = strobe[PH_Q4] & ~ir_flushed;

    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        dmem_rd |-> (phase == 4'b0010 && !ir_flushed)) else $error("read strobe misplaced"); // R6
    AST_WR_WINDOW: assert property (@(posedge clk) disable iff (rst)
        dmem_wr |-> (phase == 4'b1000 && !ir_flushed)) else $error("write strobe misplaced"); // R6
    AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (rst)
        (br_req && phase[3] && !ir_flushed) |=> (imem_addr == $past(br_target) && ir_flushed))
        else $error("branch not taken"); // R7
    AST_NO_FLUSH_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (phase[3] && ir_flushed) |=> !ir_flushed) else $error("branch taken in flushed cycle"); // R9
endmodule

// File: tb/qseq_core_bench.sv
module qseq_core_bench;
    localparam int PC_W = 16;
    localparam int IW   = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] imem_addr;
    logic [IW-1:0]   imem_data;
    logic            br_req = 1'b0;
    logic [PC_W-1:0] br_target = '0;
    logic [3:0]      phase;
    logic [IW-1:0]   ir;
    logic            ir_flushed;
    logic            dmem_rd, dmem_wr;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    qseq_core #(.PC_W(PC_W), .IW(IW)) u_qseq_core (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .br_req(br_req), .br_target(br_target), .phase(phase), .ir(ir),
        .ir_flushed(ir_flushed), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr)
    );

    function automatic logic [IW-1:0] mem_f(input logic [PC_W-1:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + 8'h01};
    endfunction

    assign imem_data = mem_f(imem_addr);

    // Behavioural reference: integer phase count, expected PC, fetched word, executing word.
    int              m_ph  = 0;
    logic [PC_W-1:0] m_pc  = '0;
    logic [IW-1:0]   m_pf  = '0;
    logic [IW-1:0]   m_ir  = '0;
    bit              m_fl  = 1'b0;
    int              n_taken = 0;
    int              n_ignored = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_pc = '0; m_pf = '0; m_ir = '0; m_fl = 1'b0;
            started = 1'b1;
        end else begin
            if (m_ph == 2) m_pf = mem_f(m_pc);
            if (m_ph == 3) begin
                if (br_req && !m_fl) begin
                    m_pc = br_target; m_ir = '0; m_fl = 1'b1; n_taken++;
                end else begin
                    if (br_req) n_ignored++;   // R9 scenario reached
                    m_pc = m_pc + 16'd2; m_ir = m_pf; m_fl = 1'b0;
                end
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic [3:0] e_ph;
            e_ph = 4'b0001 << m_ph;
            chk(phase == e_ph, rst ? "R1" : "R2", "phase", 32'(phase), 32'(e_ph));
            chk(imem_addr == m_pc, rst ? "R1" : "R3 R7", "imem_addr", 32'(imem_addr), 32'(m_pc));
            chk(ir == m_ir, rst ? "R1" : "R4 R5 R8", "ir", 32'(ir), 32'(m_ir));
            chk(ir_flushed == m_fl, rst ? "R1" : "R8 R9 R10", "ir_flushed",
                32'(ir_flushed), 32'(m_fl));
            chk(dmem_rd == (m_ph == 1 && !m_fl), "R6", "dmem_rd",
                32'(dmem_rd), 32'(m_ph == 1 && !m_fl));
            chk(dmem_wr == (m_ph == 3 && !m_fl), "R6", "dmem_wr",
                32'(dmem_wr), 32'(m_ph == 3 && !m_fl));
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3 R4: plain sequential run
        repeat (24) @(negedge clk);
        // R7 R8 R9: request held high across several cycles, target near the top to show wrap
        br_target = 16'hFFFC;
        br_req = 1'b1;
        repeat (16) @(negedge clk);
        br_req = 1'b0;
        repeat (16) @(negedge clk);
        // R7: branch to address 0
        br_target = 16'h0000;
        br_req = 1'b1;
        repeat (4) @(negedge clk);
        br_req = 1'b0;
        repeat (8) @(negedge clk);
        // R7: requests that change every clock, mostly outside Q4
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            br_req = (lfsr[2:0] == 3'd0);
            br_target = {lfsr[15:1], 1'b0};
            @(negedge clk);
        end
        br_req = 1'b0;
        repeat (8) @(negedge clk);
        chk(n_taken > 3, "R8", "branches taken", 32'(n_taken), 32'd4);
        chk(n_ignored > 0, "R9", "requests in flushed cycles", 32'(n_ignored), 32'd1);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule